// File: doc/BRIEF.md
# Interrupt and Transfer-Request Steering Fabric

This block sits between a bank of peripheral event lines and three consumers: the CPU interrupt controller, a classic DMA controller, and a descriptor-driven transfer controller. Each channel carries a peripheral interrupt, a separate transfer-request line, and a completion interrupt that comes back from the descriptor controller. Two software-written select words decide, per channel, where each of these lines goes. A read-only monitor word shows the level currently presented to the interrupt controller.

A channel is of one of two kinds, fixed at build time by a parameter bit vector. A shared-line channel uses its interrupt both as interrupt and as transfer trigger: when it is handed to the descriptor controller, the completion interrupt takes its place at the interrupt controller. A split-line channel keeps its transfer request on its own wire, and its interrupt always reaches the interrupt controller. Handing a channel to the classic DMA controller overrides everything else and silences both other paths.

The routing is purely combinational. Only the two select words are stored, and a write lands on the next clock edge.

Top module: `irq_route_fabric`

## Requirements
- R1: After reset both select words read 0, and every channel's peripheral interrupt drives its interrupt-controller output, with no request to either DMA consumer.
- R2: A write with `cfg_wr_en` high to address 0 (classic DMA select word) or address 1 (descriptor enable word) is stored at the next rising clock edge and reads back at the same address; address 3 reads as 0.
- R3: A write to address 2 (monitor word) changes neither stored select word and has no effect on routing.
- R4: With a channel's classic DMA select bit set, its peripheral interrupt appears on `dmac_req`, and its `intc_irq` and `dsc_req` bits are 0, for either channel kind.
- R5: When the classic DMA select bit and the descriptor enable bit are both set on a channel, the classic DMA behaviour of R4 applies; `dmac_req` is 0 on every channel whose classic DMA select bit is clear.
- R6: A shared-line channel (bit clear in `SPLIT_MASK`) with its enable bit clear passes the peripheral interrupt to `intc_irq`, blocks the completion interrupt, and sends nothing to `dsc_req`.
- R7: A shared-line channel with its enable bit set drives `dsc_req` from the peripheral interrupt and drives `intc_irq` from the completion interrupt only.
- R8: A split-line channel (bit set in `SPLIT_MASK`) with its enable bit clear drops the transfer-request line entirely (`dsc_req` is 0) and drives `intc_irq` with the OR of peripheral and completion interrupts.
- R9: A split-line channel with its enable bit set drives `dsc_req` from the transfer-request line only, never from the peripheral interrupt, and `intc_irq` stays the OR of peripheral and completion interrupts.
- R10: Reading address 2 returns, bit for bit, the current `intc_irq` value, including a substituted completion interrupt.
- R11: A change on the event inputs reaches the outputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the select registers |
| cfg_addr | input | 2 | Register address for write and read |
| cfg_wdata | input | NCH | Write data |
| cfg_rdata | output | NCH | Combinational read data |
| per_irq | input | NCH | Peripheral interrupt, one per channel |
| per_treq | input | NCH | Separate transfer request (used by split-line channels) |
| dsc_done | input | NCH | Completion interrupt from the descriptor controller |
| intc_irq | output | NCH | Lines to the interrupt controller |
| dmac_req | output | NCH | Transfer requests to the classic DMA controller |
| dsc_req | output | NCH | Transfer triggers to the descriptor controller |

## Verification
The only state is the two select words, so a wrong stored bit shows up as a misrouted line on the very next cycle after the faulty write: an interrupt that vanishes, a request that leaks to the wrong consumer, or a completion interrupt that reaches the interrupt controller when it should be blocked. Because the select words and the monitor can be read back at once, a corrupted bit is visible at `cfg_rdata` in the same cycle it is read. Routing faults have no latency at all; the bench drives distinct patterns on interrupt, request and completion lines so that any swapped or merged source gives a distinct wrong vector.

// File: rtl/irq_route_pkg.sv
// Shared definitions for the steering fabric: register addresses.
package irq_route_pkg;
    localparam int CFG_AW = 2;

    typedef enum logic [CFG_AW-1:0] {
        ADDR_DMA_SEL = 2'd0,
        ADDR_DSC_EN  = 2'd1,
        ADDR_MON     = 2'd2,
        ADDR_RSVD    = 2'd3
    } cfg_addr_e;
endpackage

// File: rtl/irq_route_cfg.sv
// Select-word storage. Holds the classic DMA select word and the
// descriptor enable word. Assumes one write per cycle; writes to any
// other address leave both words untouched.
module irq_route_cfg
    import irq_route_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [NCH-1:0]    wdata,
    output logic [NCH-1:0]    dma_sel,
    output logic [NCH-1:0]    dsc_en
);
    logic wr_dma;
    logic wr_dsc;

    // Decode which word a write targets.
    always_comb begin
        wr_dma = wr_en && (cfg_addr_e'(addr) == ADDR_DMA_SEL);
        wr_dsc = wr_en && (cfg_addr_e'(addr) == ADDR_DSC_EN);
    end

    // Classic DMA select word, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_sel <= '0;
        end else if (wr_dma) begin
            dma_sel <= wdata;
        end
    end

    // Descriptor enable word, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsc_en <= '0;
        end else if (wr_dsc) begin
            dsc_en <= wdata;
        end
    end
endmodule

// File: rtl/irq_route_lane.sv
// One channel of the steering fabric. The SPLIT parameter picks the
// channel kind at build time. Purely combinational; classic DMA select
// overrides the descriptor enable.
module irq_route_lane #(
    parameter bit SPLIT = 1'b0
) (
    input  logic irq,
    input  logic treq,
    input  logic done,
    input  logic dma_sel,
    input  logic dsc_en,
    output logic intc,
    output logic dmac,
    output logic dsc
);
    logic intc_native;
    logic dsc_native;

    generate
        if (SPLIT) begin : g_split
            // Split-line channel: interrupt always merged with completion.
            always_comb begin
                intc_native = irq | done;
                dsc_native  = dsc_en & treq;
            end
        end else begin : g_shared
            logic unused_treq;
            assign unused_treq = treq;
            // Shared-line channel: enable swaps interrupt for completion.
            always_comb begin
                intc_native = dsc_en ? done : irq;
                dsc_native  = dsc_en & irq;
            end
        end
    endgenerate

    // Classic DMA select silences the other two consumers.
    always_comb begin
        dmac = dma_sel & irq;
        intc = dma_sel ? 1'b0 : intc_native;
        dsc  = dma_sel ? 1'b0 : dsc_native;
    end
endmodule

// File: rtl/irq_route_rdmux.sv
// Read-back multiplexer: select words, monitor word, zero for the
// unused address. Combinational.
module irq_route_rdmux
    import irq_route_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic [CFG_AW-1:0] addr,
    input  logic [NCH-1:0]    dma_sel,
    input  logic [NCH-1:0]    dsc_en,
    input  logic [NCH-1:0]    mon,
    output logic [NCH-1:0]    rdata
);
    // Pick the word named by the address.
    always_comb begin
        unique case (cfg_addr_e'(addr))
            ADDR_DMA_SEL: rdata = dma_sel;
            ADDR_DSC_EN:  rdata = dsc_en;
            ADDR_MON:     rdata = mon;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_route_fabric.sv
// Top of the steering fabric. Stores two select words, instantiates one
// lane per channel with its kind taken from SPLIT_MASK, and exposes the
// interrupt-controller level as a read-only monitor word.
module irq_route_fabric
    import irq_route_pkg::*;
#(
    parameter int           NCH        = 32,
    parameter logic [NCH-1:0] SPLIT_MASK = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [NCH-1:0]    cfg_wdata,
    output logic [NCH-1:0]    cfg_rdata,
    input  logic [NCH-1:0]    per_irq,
    input  logic [NCH-1:0]    per_treq,
    input  logic [NCH-1:0]    dsc_done,
    output logic [NCH-1:0]    intc_irq,
    output logic [NCH-1:0]    dmac_req,
    output logic [NCH-1:0]    dsc_req
);
    logic [NCH-1:0] dma_sel_q;
    logic [NCH-1:0] dsc_en_q;

    irq_route_cfg #(.NCH(NCH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .dma_sel (dma_sel_q),
        .dsc_en  (dsc_en_q)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
            irq_route_lane #(.SPLIT(SPLIT_MASK[ch])) u_lane (
                .irq     (per_irq[ch]),
                .treq    (per_treq[ch]),
                .done    (dsc_done[ch]),
                .dma_sel (dma_sel_q[ch]),
                .dsc_en  (dsc_en_q[ch]),
                .intc    (intc_irq[ch]),
                .dmac    (dmac_req[ch]),
                .dsc     (dsc_req[ch])
            );
        end
    endgenerate

    irq_route_rdmux #(.NCH(NCH)) u_rdmux (
        .addr    (cfg_addr),
        .dma_sel (dma_sel_q),
        .dsc_en  (dsc_en_q),
        .mon     (intc_irq),
        .rdata   (cfg_rdata)
    );
endmodule

// File: rtl/irq_route_fabric_chk.sv
// Property checker for the steering fabric, attached by bind.
module irq_route_fabric_chk
    import irq_route_pkg::*;
#(
    parameter int           NCH        = 32,
    parameter logic [NCH-1:0] SPLIT_MASK = 32'hFFFF_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [NCH-1:0]    cfg_wdata,
    input logic [NCH-1:0]    cfg_rdata,
    input logic [NCH-1:0]    per_irq,
    input logic [NCH-1:0]    per_treq,
    input logic [NCH-1:0]    intc_irq,
    input logic [NCH-1:0]    dmac_req,
    input logic [NCH-1:0]    dsc_req,
    input logic [NCH-1:0]    dma_sel_q,
    input logic [NCH-1:0]    dsc_en_q
);
    assert_wr_dma_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == ADDR_DMA_SEL) |=> (dma_sel_q == $past(cfg_wdata)));

    assert_wr_dsc_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == ADDR_DSC_EN) |=> (dsc_en_q == $past(cfg_wdata)));

    assert_mon_write_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == ADDR_MON) |=> ($stable(dma_sel_q) && $stable(dsc_en_q)));

    assert_dma_silences_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_sel_q & (intc_irq | dsc_req)) == '0));

    assert_dmac_only_when_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((dmac_req & ~dma_sel_q) == '0));

    assert_shared_dsc_from_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dsc_req & ~SPLIT_MASK & ~per_irq) == '0));

    assert_split_drop_treq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((dsc_req & SPLIT_MASK & ~dsc_en_q) == '0));

    assert_split_dsc_from_treq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((dsc_req & SPLIT_MASK & ~per_treq) == '0));

    assert_monitor_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == ADDR_MON) |-> (cfg_rdata == intc_irq));
endmodule

bind irq_route_fabric irq_route_fabric_chk #(
    .NCH        (NCH),
    .SPLIT_MASK (SPLIT_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .per_irq   (per_irq),
    .per_treq  (per_treq),
    .intc_irq  (intc_irq),
    .dmac_req  (dmac_req),
    .dsc_req   (dsc_req),
    .dma_sel_q (dma_sel_q),
    .dsc_en_q  (dsc_en_q)
);

// File: tb/irq_route_fabric_bench.sv
// Directed bench for the steering fabric. Channels 0..15 are shared-line,
// 16..31 split-line. Inputs change at the falling edge; outputs are
// sampled 1 ns later.
module irq_route_fabric_bench;
    localparam int NCH = 32;
    localparam logic [NCH-1:0] SPLIT = 32'hFFFF_0000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_wr_en = 1'b0;
    logic [1:0]     cfg_addr = 2'd0;
    logic [NCH-1:0] cfg_wdata = '0;
    logic [NCH-1:0] cfg_rdata;
    logic [NCH-1:0] per_irq = '0;
    logic [NCH-1:0] per_treq = '0;
    logic [NCH-1:0] dsc_done = '0;
    logic [NCH-1:0] intc_irq;
    logic [NCH-1:0] dmac_req;
    logic [NCH-1:0] dsc_req;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;
    logic [NCH-1:0] exp_sel = '0;
    logic [NCH-1:0] exp_en = '0;

    always #4 clk = ~clk;

    irq_route_fabric #(.NCH(NCH), .SPLIT_MASK(SPLIT)) u_irq_route_fabric (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_irq(per_irq),
        .per_treq(per_treq), .dsc_done(dsc_done), .intc_irq(intc_irq),
        .dmac_req(dmac_req), .dsc_req(dsc_req)
    );

    task automatic check(input string req, input string what,
                         input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [NCH-1:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wdata = '0;
        if (a == 2'd0) exp_sel = d;
        if (a == 2'd1) exp_en = d;
    endtask

    task automatic rd(input logic [1:0] a, output logic [NCH-1:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // Expected routing built from R4..R9.
    task automatic check_routes(input string req);
        logic [NCH-1:0] ei, ed, es;
        for (int i = 0; i < NCH; i++) begin
            ed[i] = 1'b0; ei[i] = 1'b0; es[i] = 1'b0;
            if (exp_sel[i]) begin
                ed[i] = per_irq[i];
            end else if (!SPLIT[i]) begin
                ei[i] = exp_en[i] ? dsc_done[i] : per_irq[i];
                es[i] = exp_en[i] & per_irq[i];
            end else begin
                ei[i] = per_irq[i] | dsc_done[i];
                es[i] = exp_en[i] & per_treq[i];
            end
        end
        #1;
        check(req, "intc_irq", intc_irq, ei);
        check(req, "dmac_req", dmac_req, ed);
        check(req, "dsc_req", dsc_req, es);
    endtask

    task automatic drive(input logic [NCH-1:0] i, input logic [NCH-1:0] t,
                         input logic [NCH-1:0] d);
        per_irq = i; per_treq = t; dsc_done = d;
    endtask

    task automatic t_reset;
        logic [NCH-1:0] v;
        rd(2'd0, v); check("R1", "dma select after reset", v, '0);
        rd(2'd1, v); check("R1", "enable after reset", v, '0);
        @(negedge clk);
        drive(32'hA5A5_3C3C, 32'hFFFF_FFFF, 32'h0F0F_0F0F);
        #1;
        check("R1", "intc after reset", intc_irq, 32'hA5A5_3C3C | (32'h0F0F_0F0F & SPLIT));
        check("R1", "no dmac after reset", dmac_req, '0);
        check("R1", "no dsc after reset", dsc_req, '0);
    endtask

    task automatic t_regs;
        logic [NCH-1:0] v;
        wr(2'd0, 32'h1234_5678); rd(2'd0, v); check("R2", "dma select readback", v, 32'h1234_5678);
        wr(2'd1, 32'h8765_4321); rd(2'd1, v); check("R2", "enable readback", v, 32'h8765_4321);
        rd(2'd3, v); check("R2", "reserved reads zero", v, '0);
        wr(2'd0, '0); wr(2'd1, '0);
    endtask

    task automatic t_mon_write;
        logic [NCH-1:0] v;
        wr(2'd0, 32'h0000_00F0); wr(2'd1, 32'h00F0_000F);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R3", "dma select kept", v, 32'h0000_00F0);
        rd(2'd1, v); check("R3", "enable kept", v, 32'h00F0_000F);
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
        check_routes("R3");
        wr(2'd0, '0); wr(2'd1, '0);
    endtask

    task automatic t_shared;
        wr(2'd1, 32'h0000_00FF);
        drive(32'h0000_0F0F, 32'h0000_FFFF, 32'h0000_3333);
        check_routes("R6");
        #1;
        check("R6", "shared disabled ignores done", intc_irq[15:8], 8'h0F);
        check("R7", "shared enabled shows done", intc_irq[7:0], 8'h33);
        check("R7", "shared enabled trigger", dsc_req[7:0], 8'h0F);
        drive(32'h0000_00F0, 32'h0, 32'h0000_0055);
        check_routes("R7");
        wr(2'd1, '0);
    endtask

    task automatic t_split;
        drive(32'h00FF_0000, 32'hF0F0_0000, 32'h0F00_0000);
        check_routes("R8");
        check("R8", "split disabled no dsc", dsc_req, '0);
        wr(2'd1, 32'hFF00_0000);
        drive(32'hAA00_0000, 32'h3C00_0000, 32'h0500_0000);
        check_routes("R9");
        check("R9", "split trigger from treq", dsc_req, 32'h3C00_0000);
        check("R9", "split intc is OR", intc_irq, 32'hAF00_0000);
        wr(2'd1, '0);
    endtask

    task automatic t_dma;
        wr(2'd0, 32'h0F00_000F);
        wr(2'd1, 32'h0300_0003);
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_routes("R5");
        check("R4", "dma channels silent on intc", intc_irq & 32'h0F00_000F, '0);
        check("R5", "dma wins over enable", dmac_req, 32'h0F00_000F);
        drive(32'h0500_0005, 32'h0, 32'h0);
        check_routes("R4");
        wr(2'd0, '0); wr(2'd1, '0);
    endtask

    task automatic t_monitor;
        logic [NCH-1:0] v;
        wr(2'd1, 32'h0000_0003);
        drive(32'h0001_0001, 32'h0, 32'h0002_0002);
        rd(2'd2, v); check("R10", "monitor with substitution", v, 32'h0003_0002);
        // R11: change inputs between edges and look before the next edge.
        drive(32'h0000_0004, 32'h0, 32'h0000_0001);
        rd(2'd2, v); check("R11", "same-cycle monitor", v, 32'h0000_0005);
        check_routes("R11");
        wr(2'd1, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_mon_write();
        t_shared();
        t_split();
        t_dma();
        t_monitor();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule